// File: doc/BRIEF.md
# Indirect Branch Target Tag Sanitizer

This block sits at the end of the register-indirect branch path. It takes a 64-bit target read from a general register and produces the value to load into the program counter. When address tagging is on, it rewrites the top byte (bits 63:56), which holds the tag. The rewrite depends on the privilege level and on two tag-ignore enables, one for the lower half of the address space and one for the upper half. At the two low privilege levels, bit 55 of the target picks which enable applies, and the tag byte is filled with copies of bit 55. At the two high levels, only the lower-half enable counts, and it clears the tag byte to zero.

A plain branch, a branch-with-link and a return all pass through the same sanitizing path. A branch-with-link also writes the address of the next sequential instruction (the current PC plus 4) to link register 30. All results are registered one cycle after a valid request and are held until the next valid request.

Top module: `ibr_tag_sanitizer`

## Requirements
- R1: After reset, `pc_load` and `lr_we` are 0.
- R2: At privilege level 0 or 1 with both enables set, `pc_new[63:56]` equals eight copies of `tgt[55]`.
- R3: At privilege level 0 or 1 with neither enable set, `pc_new` equals `tgt`.
- R4: At privilege level 0 or 1 with only `tbi_lo` set, the tag byte becomes 0 when `tgt[55]`=0, and `tgt` passes unchanged when `tgt[55]`=1.
- R5: At privilege level 0 or 1 with only `tbi_hi` set, the tag byte becomes 8'hFF when `tgt[55]`=1, and `tgt` passes unchanged when `tgt[55]`=0.
- R6: At privilege level 2 or 3, `tbi_hi` is ignored. With `tbi_lo`=1 the tag byte is cleared; with `tbi_lo`=0, `tgt` passes unchanged.
- R7: `pc_new[55:0]` always equals `tgt[55:0]`.
- R8: The kind encoding is 2'b00 branch, 2'b01 branch-with-link and 2'b10 return. All three raise `pc_load` for one cycle, one cycle after `valid`, with the same sanitized `pc_new`. Kind 2'b11 raises neither `pc_load` nor `lr_we`.
- R9: Kind 2'b01 raises `lr_we` in the same cycle as `pc_load`, with `lr_idx`=30 and `lr_data` = the `pc` sampled with `valid`, plus 4.
- R10: `pc_new`, `lr_data` and `lr_idx` hold their values while `valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid | input | 1 | Request strobe |
| kind | input | 2 | Branch kind |
| priv | input | 2 | Privilege level 0 to 3 |
| tbi_lo | input | 1 | Tag-ignore enable, lower half |
| tbi_hi | input | 1 | Tag-ignore enable, upper half |
| tgt | input | 64 | Register target address |
| pc | input | 64 | Current PC |
| pc_new | output | 64 | Sanitized PC value |
| pc_load | output | 1 | PC load strobe |
| lr_data | output | 64 | Link value |
| lr_idx | output | 5 | Link register index |
| lr_we | output | 1 | Link write strobe |

## Verification
A wrong choice of enable or of fill value shows up in `pc_new[63:56]` one cycle after the request. Corrupted low bits show in `pc_new[55:0]` in that same cycle. A strobe or link error shows in the same cycle on `pc_load`, `lr_we` or `lr_data`. Any hold defect shows up as a change in the held outputs during the idle cycles that follow.

// File: rtl/ibr_tag_sanitizer.sv
module ibr_tag_sanitizer #(
  parameter int AW = 64,
  parameter int TAGW = 8,
  parameter int LR_REG = 30,
  parameter int INSN_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic [1:0]    kind,
  input  logic [1:0]    priv,
  input  logic          tbi_lo,
  input  logic          tbi_hi,
  input  logic [AW-1:0] tgt,
  input  logic [AW-1:0] pc,
  output logic [AW-1:0] pc_new,
  output logic          pc_load,
  output logic [AW-1:0] lr_data,
  output logic [4:0]    lr_idx,
  output logic          lr_we
);
  localparam int SB = AW - TAGW - 1;
  localparam logic [1:0] K_BR = 2'b00, K_BL = 2'b01, K_RET = 2'b10;

  logic low_el, sel_bit, strip;
  logic [TAGW-1:0] fill;
  logic [AW-1:0] clean;
  logic take;

  assign low_el  = ~priv[1];
  assign sel_bit = tgt[SB];
  assign strip   = low_el ? (sel_bit ? tbi_hi : tbi_lo) : tbi_lo;
  assign fill    = (low_el && sel_bit) ? {TAGW{1'b1}} : {TAGW{1'b0}};
  assign clean   = strip ? {fill, tgt[SB:0]} : tgt;
  assign take    = valid && (kind == K_BR || kind == K_BL || kind == K_RET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_new  <= '0;
      pc_load <= 1'b0;
      lr_data <= '0;
      lr_idx  <= 5'd0;
      lr_we   <= 1'b0;
    end else begin
      pc_load <= take;
      lr_we   <= take && kind == K_BL;
      if (take) pc_new <= clean;
      if (take && kind == K_BL) begin
        lr_data <= pc + AW'(INSN_BYTES);
        lr_idx  <= 5'(LR_REG);
      end
    end
  end

  // R7
  low_bits_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> pc_new[SB:0] == $past(tgt[SB:0]));
  // R8
  kind3_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && kind == 2'b11) |=> !pc_load && !lr_we);
  // R9
  link_pairs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lr_we |-> pc_load && lr_idx == 5'(LR_REG));
  // R10
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(pc_new) && $stable(lr_data));
  // R6
  high_el_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && kind != 2'b11 && priv[1] && tbi_lo) |=> pc_new[AW-1:AW-TAGW] == '0);
endmodule

// File: tb/sim_ibr_tag_sanitizer.sv
module sim_ibr_tag_sanitizer;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0, valid = 0, tbi_lo = 0, tbi_hi = 0;
  logic [1:0] kind = 0, priv = 0;
  logic [63:0] tgt = 0, pc = 0;
  logic [63:0] pc_new, lr_data;
  logic pc_load, lr_we;
  logic [4:0] lr_idx;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ibr_tag_sanitizer u0 (.clk, .rst_n, .valid, .kind, .priv, .tbi_lo, .tbi_hi,
    .tgt, .pc, .pc_new, .pc_load, .lr_data, .lr_idx, .lr_we);

  function automatic logic [63:0] model(logic [1:0] p, logic lo, logic hi, logic [63:0] t);
    if (p < 2) begin
      if (lo && hi) return {{8{t[55]}}, t[55:0]};
      if (!lo && !hi) return t;
      if (lo) return t[55] ? t : {8'h00, t[55:0]};
      return t[55] ? {8'hFF, t[55:0]} : t;
    end
    return lo ? {8'h00, t[55:0]} : t;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(logic [1:0] p, logic lo, logic hi);
    if (p >= 2) return "R6";
    if (lo && hi) return "R2";
    if (!lo && !hi) return "R3";
    return lo ? "R4" : "R5";
  endfunction

  task automatic issue(logic [1:0] k, logic [1:0] p, logic lo, logic hi,
                       logic [63:0] t, logic [63:0] c);
    logic [63:0] prev_pc;
    prev_pc = pc_new;
    @(negedge clk);
    valid = 1; kind = k; priv = p; tbi_lo = lo; tbi_hi = hi; tgt = t; pc = c;
    @(negedge clk);
    valid = 0; tgt = ~t; pc = ~c; kind = 2'b00;
    if (k == 2'b11) begin
      chk("R8 load", {63'd0, pc_load}, 64'd0);
      chk("R8 link", {63'd0, lr_we}, 64'd0);
      chk("R8 hold", pc_new, prev_pc);
    end else begin
      chk("R8 load", {63'd0, pc_load}, 64'd1);
      chk(req_of(p, lo, hi), pc_new, model(p, lo, hi, t));
      chk("R7", {8'd0, pc_new[55:0]}, {8'd0, t[55:0]});
      chk("R9 we", {63'd0, lr_we}, {63'd0, k == 2'b01});
      if (k == 2'b01) begin
        chk("R9 data", lr_data, c + 64'd4);
        chk("R9 idx", {59'd0, lr_idx}, 64'd30);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] held_pc, held_lr;
    void'($urandom(32'd1234));
    #(CLK_PERIOD*2);
    chk("R1 load", {63'd0, pc_load}, 64'd0);
    chk("R1 link", {63'd0, lr_we}, 64'd0);
    @(negedge clk); rst_n = 1;
    for (int p = 0; p < 4; p++)
      for (int e = 0; e < 4; e++)
        for (int b = 0; b < 2; b++)
          for (int k = 0; k < 3; k++) begin
            logic [63:0] t;
            t = {$urandom, $urandom};
            t[55] = b[0];
            issue(k[1:0], p[1:0], e[0], e[1], t, {$urandom, $urandom});
          end
    issue(2'b01, 2'd0, 1, 1, 64'h5A80_0000_0000_1000, 64'hFFFF_FFFF_FFFF_FFFC);
    issue(2'b00, 2'd3, 0, 1, 64'hA5FF_FFFF_FFFF_FFFF, 64'd0);
    issue(2'b11, 2'd1, 1, 1, 64'h1234_5678_9ABC_DEF0, 64'h100);
    for (int i = 0; i < 300; i++)
      issue(2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
            {$urandom, $urandom}, {$urandom, $urandom});
    issue(2'b01, 2'd1, 0, 1, 64'h0080_0000_0000_0040, 64'h2000);
    held_pc = pc_new; held_lr = lr_data;
    repeat (3) @(negedge clk);
    chk("R10 pc", pc_new, held_pc);
    chk("R10 lr", lr_data, held_lr);
    chk("R10 strobe", {63'd0, pc_load}, 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule